// File: doc/BRIEF.md
# Column-Scanned Dot-Matrix Level Meter

This block turns an 8-bit converter reading into the drive for a 16x16 LED dot matrix. The matrix is used as an area-style level meter. A 4-bit scan index steps through the columns, one column per clock. The block emits an inverted 4-bit column code for an external 4-to-16 decoder, and for each column it emits a 16-bit row pattern.

In area mode the upper nibble of the reading gives the number of fully lit columns. The column that follows them carries a partial bar whose height is the lower nibble, and every column past it is dark. That gives 256 distinct images. In bar mode only the first (rightmost) column is used, as a 16-level bar set by the upper nibble.

The reading and the mode are held for a whole frame. They are taken only at the frame boundary, so a frame never mixes two values.

Top module: `matrix_level_meter`

## Requirements
- R1: While reset is asserted, the column code is 1111, every row bit is 0, the held reading is 0 and the held mode is area.
- R2: After reset the scan index starts at 0 and rises by one every clock, wrapping from 15 to 0. The column code is the bitwise inverse of the index, so 1111 selects column 1 (the rightmost) and 0000 selects column 16. The column code and its row pattern change on the same clock edge.
- R3: In area mode (barMode = 0), a column whose scan index is below the held upper nibble (bits 7:4) drives all 16 row bits high.
- R4: In area mode, the column whose scan index equals the held upper nibble lights as many rows as the held lower nibble (bits 3:0). The lit rows fill from the bottom: row bit r drives row r, row 0 is the top and row 15 the bottom, so n lit rows are bits 15 down to 16-n.
- R5: In area mode, a column whose scan index is above the held upper nibble drives all row bits low.
- R6: In bar mode (barMode = 1), the column with scan index 0 (code 1111) lights as many rows as the held upper nibble, filling from the bottom as in R4. Every other column is dark.
- R7: sampleIn and barMode are taken only on the clock edge at which the column code becomes 0000. They first show on the next column with code 1111. Changes at any other time have no effect on the frame being shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one column per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 8 | Conversion result to display |
| barMode | input | 1 | 1 = single-column bar, 0 = area meter |
| colSel | output | 4 | Inverted column code to the external decoder |
| rowBits | output | 16 | Row pattern for the selected column, bit 0 = top row |

## Verification
The assertions check on every cycle that the scan index steps by one and that the column code follows it. They also check that full, partial and dark columns follow the held nibbles in area mode, that bar mode leaves all columns except the first dark, and that the held reading cannot move except at the wrap. What only the bench's scenarios can show is the frame-level result. A value presented mid-frame must appear exactly from the next 1111 column, the extreme readings 0x00, 0x0F, 0xF0 and 0xFF must give the correct images, and a bench model built from the requirements must match the rows bit for bit.

// File: rtl/matrix_level_pkg.sv
package matrix_level_pkg;

  typedef enum logic {
    MODE_AREA = 1'b0,
    MODE_BAR  = 1'b1
  } dispMode_t;

  typedef struct packed {
    logic capture;    // frame boundary: latch new reading
    logic firstCol;   // scan sits on the rightmost column
  } scanStrobe_t;

endpackage

// File: rtl/matrix_scan_ctrl.sv
module matrix_scan_ctrl
  import matrix_level_pkg::*;
#(
  parameter int COL_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [COL_BITS-1:0] scanIdx,
  output scanStrobe_t         strobes
);

  localparam logic [COL_BITS-1:0] LAST_IDX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) scanIdx <= '0;
    else       scanIdx <= scanIdx + 1'b1;
  end

  always_comb begin
    strobes.capture  = (scanIdx == LAST_IDX);
    strobes.firstCol = (scanIdx == '0);
  end

  // R2: the scan index advances by exactly one each clock
  a_r2_scan_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> scanIdx == $past(scanIdx) + 1'b1);

endmodule

// File: rtl/matrix_level_dp.sv
module matrix_level_dp
  import matrix_level_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COL_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                barMode,
  input  logic [COL_BITS-1:0] scanIdx,
  input  scanStrobe_t         strobes,
  output logic [COL_BITS-1:0] colSel,
  output logic [(1<<(SAMPLE_W-COL_BITS))-1:0] rowBits
);

  localparam int FINE_W = SAMPLE_W - COL_BITS;
  localparam int ROWS   = 1 << FINE_W;
  localparam int CNT_W  = $clog2(ROWS + 1);
  localparam int SUM_W  = CNT_W + 1;

  logic [SAMPLE_W-1:0] heldVal;
  dispMode_t           heldMode;
  logic [COL_BITS-1:0] coarse;
  logic [FINE_W-1:0]   fine;
  logic [CNT_W-1:0]    fillCount;
  logic [ROWS-1:0]     fillMask;

  // Hold the reading for a full frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldVal  <= '0;
      heldMode <= MODE_AREA;
    end else if (strobes.capture) begin
      heldVal  <= sampleIn;
      heldMode <= dispMode_t'(barMode);
    end
  end

  assign coarse = heldVal[SAMPLE_W-1 -: COL_BITS];
  assign fine   = heldVal[FINE_W-1:0];

  // How many rows of the current column are lit
  always_comb begin
    if (heldMode == MODE_BAR) begin
      fillCount = strobes.firstCol ? CNT_W'(coarse) : '0;
    end else if (scanIdx < coarse) begin
      fillCount = CNT_W'(ROWS);
    end else if (scanIdx == coarse) begin
      fillCount = CNT_W'(fine);
    end else begin
      fillCount = '0;
    end
  end

  // Bottom-up fill: row r lit when r + count reaches the row total
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign fillMask[r] = (SUM_W'(r) + SUM_W'(fillCount)) >= SUM_W'(ROWS);
  end

  // Column code and rows leave together from one register stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colSel  <= '1;
      rowBits <= '0;
    end else begin
      colSel  <= ~scanIdx;
      rowBits <= fillMask;
    end
  end

  // R2: column code is the inverse of the index of the previous cycle
  a_r2_col_code: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> colSel == ~$past(scanIdx));

  // R3: columns below the coarse level are fully lit
  a_r3_full_below: assert property (@(posedge clk) disable iff (!rstN)
    (heldMode == MODE_AREA && scanIdx < coarse) |=> rowBits == '1);

  // R4: the boundary column lights exactly the fine count
  a_r4_partial_count: assert property (@(posedge clk) disable iff (!rstN)
    (heldMode == MODE_AREA && scanIdx == coarse)
      |=> $countones(rowBits) == $past(int'(fine)));

  // R5: columns above the coarse level are dark
  a_r5_dark_above: assert property (@(posedge clk) disable iff (!rstN)
    (heldMode == MODE_AREA && scanIdx > coarse) |=> rowBits == '0);

  // R6: bar mode uses only the first column
  a_r6_bar_single: assert property (@(posedge clk) disable iff (!rstN)
    (heldMode == MODE_BAR && scanIdx != '0) |=> rowBits == '0);

  // R7: the held reading moves only at the frame boundary
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(heldVal) && $stable(heldMode));

endmodule

// File: rtl/matrix_level_meter.sv
module matrix_level_meter
  import matrix_level_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COL_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                barMode,
  output logic [COL_BITS-1:0] colSel,
  output logic [(1<<(SAMPLE_W-COL_BITS))-1:0] rowBits
);

  logic [COL_BITS-1:0] scanIdx;
  scanStrobe_t         strobes;

  matrix_scan_ctrl #(.COL_BITS(COL_BITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .scanIdx (scanIdx),
    .strobes (strobes)
  );

  matrix_level_dp #(.SAMPLE_W(SAMPLE_W), .COL_BITS(COL_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .barMode  (barMode),
    .scanIdx  (scanIdx),
    .strobes  (strobes),
    .colSel   (colSel),
    .rowBits  (rowBits)
  );

endmodule

// File: tb/matrix_level_meter_test.sv
module matrix_level_meter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  sampleIn = 8'h00;
  logic        barMode = 1'b0;
  logic [3:0]  colSel;
  logic [15:0] rowBits;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] modelIdx;
  logic [7:0] dispVal;
  logic       dispMode;

  always #2 clk = ~clk;

  matrix_level_meter uut (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .barMode  (barMode),
    .colSel   (colSel),
    .rowBits  (rowBits)
  );

  function automatic logic [15:0] expRows(int idx, logic [7:0] v, logic m);
    int n;
    logic [15:0] res;
    if (m) n = (idx == 0) ? int'(v[7:4]) : 0;
    else if (idx < int'(v[7:4])) n = 16;
    else if (idx == int'(v[7:4])) n = int'(v[3:0]);
    else n = 0;
    for (int r = 0; r < 16; r++) res[r] = (r >= 16 - n);
    return res;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic tick();
    logic [3:0]  expCol;
    logic [15:0] expRow;
    string tag;
    @(negedge clk);
    expCol = ~modelIdx;
    expRow = expRows(int'(modelIdx), dispVal, dispMode);
    checks++;
    if (colSel !== expCol) begin
      errors++;
      $display("FAIL R2 colSel got %b exp %b", colSel, expCol);
    end
    if (sampleIn != dispVal || barMode != dispMode) tag = "R7";
    else if (dispMode) tag = "R6";
    else if (modelIdx < dispVal[7:4]) tag = "R3";
    else if (modelIdx == dispVal[7:4]) tag = "R4";
    else tag = "R5";
    checks++;
    if (rowBits !== expRow) begin
      errors++;
      $display("FAIL %s rowBits col %0d val %h mode %0d got %h exp %h",
               tag, modelIdx, dispVal, dispMode, rowBits, expRow);
    end
    if (modelIdx == 4'hF) begin
      dispVal  = sampleIn;
      dispMode = barMode;
    end
    modelIdx = modelIdx + 1'b1;
  endtask

  task automatic holdFrames(logic [7:0] v, logic m, int frames);
    sampleIn = v;
    barMode  = m;
    for (int k = 0; k < frames * 16; k++) tick();
  endtask

  initial begin
    #(150000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int unused;
    unused = $urandom(20240611);
    modelIdx = 4'h0;
    dispVal  = 8'h00;
    dispMode = 1'b0;
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (colSel !== 4'hF || rowBits !== 16'h0000) begin
      errors++;
      $display("FAIL R1 reset got %b/%h exp 1111/0000", colSel, rowBits);
    end
    sampleIn = 8'hA7;  // not visible until the first capture (R7)
    rstN = 1'b1;
    // Directed area corners: R3 R4 R5
    holdFrames(8'h00, 1'b0, 2);
    holdFrames(8'h0F, 1'b0, 2);
    holdFrames(8'hF0, 1'b0, 2);
    holdFrames(8'hFF, 1'b0, 2);
    holdFrames(8'h80, 1'b0, 2);
    holdFrames(8'h3C, 1'b0, 2);
    // Directed bar cases: R6
    holdFrames(8'h00, 1'b1, 2);
    holdFrames(8'hF0, 1'b1, 2);
    holdFrames(8'h5A, 1'b1, 2);
    // Mid-frame change must not tear the image: R7
    holdFrames(8'h47, 1'b0, 1);
    for (int k = 0; k < 8; k++) tick();
    sampleIn = 8'hC2;
    barMode  = 1'b1;
    for (int k = 0; k < 8 + 32; k++) tick();
    // Random frames, with inputs also moving inside frames
    for (int f = 0; f < 200; f++) begin
      sampleIn = 8'($urandom);
      barMode  = ($urandom % 4) == 0;
      for (int k = 0; k < 16; k++) begin
        if (($urandom % 5) == 0) sampleIn = 8'($urandom);
        if (($urandom % 11) == 0) barMode = ~barMode;
        tick();
      end
    end
    report();
  end

endmodule